// File: doc/BRIEF.md
# Stop-State Clock Gating and Wake Controller

This controller places a processor core in its lowest-power stop state and brings it back out. It runs entirely on a free-running internal low-frequency RC clock, which is the only clock left running while the core is stopped. When software asks for stop, the core clock is gated first and then the external oscillator is switched off. From then on the controller watches three wake sources in the RC domain: an external interrupt pin, activity on the SPI bus, and an expiry pulse from an interval timer. Each source has an enable bit.

When an enabled source fires, the controller switches the external oscillator back on and waits a programmable number of RC cycles for it to settle. It then ungates the core clock and returns to the run state. A cause register keeps one sticky bit per source, so software can see what woke the core. Software clears that register with a write pulse. Every asynchronous input passes through a two-flop synchronizer. A stop request is refused while any enabled source is already active, so no wake event can be lost on the way into stop.

The state machine has four states. RUN: the core is clocked. DRAIN: the core clock is gated and the oscillator is still on. STOP: both are off. SETTLE: the oscillator is on and the core clock is still gated. The transitions are:
- RUN to DRAIN on an accepted stop request.
- DRAIN to STOP when no wake is present.
- DRAIN to SETTLE or STOP to SETTLE on a wake.
- SETTLE to RUN when the settle count is used up.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, core_clk_en and xosc_en are 1 and wake_cause is 0.
- R2: A rising edge of stop_req in RUN is seen through a two-flop synchronizer. On the third rising rc_clk edge after stop_req goes high, core_clk_en drops to 0 while xosc_en stays 1. On the fourth edge xosc_en drops to 0.
- R3: The external pin is wake_src bit 0, enabled by wake_en bit 0. When it is high in stop, the core wakes and wake_cause bit 0 is set.
- R4: SPI bus activity is wake_src bit 1, enabled by wake_en bit 1. When it is high in stop, the core wakes and wake_cause bit 1 is set.
- R5: The interval-timer expiry is wake_src bit 2, enabled by wake_en bit 2. A single-cycle pulse on it wakes the core from stop and sets wake_cause bit 2.
- R6: A source whose enable bit is 0 does not wake the core and does not change wake_cause. Both clock controls stay 0.
- R7: On the third edge after an enabled source goes high in stop, xosc_en rises while core_clk_en stays 0. core_clk_en rises settle_len+1 edges after that. core_clk_en is never 1 while xosc_en is 0.
- R8: A stop request is ignored while any enabled wake source is high after synchronization. Both clock controls stay 1.
- R9: On a wake, every enabled source that is active in that cycle is ORed into wake_cause. A one-cycle cause_clr pulse clears wake_cause on the next edge. Otherwise wake_cause holds its value.
- R10: After a wake, stop is entered again only on a new rising edge of stop_req. A stop_req that stays high does not re-enter stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Always-on internal RC oscillator clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| stop_req | input | 1 | Stop request level from software, acted on at its rising edge |
| wake_src | input | 3 | Wake sources: bit 0 external pin, bit 1 SPI activity, bit 2 timer expiry |
| wake_en | input | 3 | Per-source wake enables, same bit order as wake_src |
| settle_len | input | SETTLE_W | Oscillator settle wait in RC cycles, minus one |
| cause_clr | input | 1 | Software clear pulse for wake_cause, RC-domain synchronous |
| core_clk_en | output | 1 | Core clock gate enable |
| xosc_en | output | 1 | External oscillator enable |
| wake_cause | output | 3 | Sticky per-source wake cause bits |

## Verification
Each wake source is tried on its own: the pin and SPI activity as held levels, and the timer as a single-cycle pulse. This shows that every bit is routed to the right cause bit and that a short pulse survives the synchronizer. A wake with two sources active together shows that the cause bits accumulate rather than pick one winner. A disabled source with an enabled one beside it separates masking from detection. A source already active when stop is requested shows that the entry guard works, as opposed to simply waking at once. The exact edge counts on entry and exit, with settle lengths of five and zero, show the sequencing of oscillator and gate. A stop request held high across a wake tells edge detection apart from level detection.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_STOP   = 2'd2,
        ST_SETTLE = 2'd3
    } swc_state_e;

    localparam int NUM_SRC = 3;
    localparam int SRC_EXT = 0;
    localparam int SRC_SPI = 1;
    localparam int SRC_TMR = 2;

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b]   <= 1'b0;
                sync_out[b] <= 1'b0;
            end else begin
                stage1[b]   <= async_in[b];
                sync_out[b] <= stage1[b];
            end
        end
    end

endmodule

// File: rtl/swc_settle_timer.sv
module swc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R7
    cnt_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !done) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/swc_cause_reg.sv
module swc_cause_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [N-1:0] set_bits,
    input  logic         clr,
    output logic [N-1:0] cause
);

    logic [N-1:0] kept;
    logic [N-1:0] added;

    always_comb begin
        kept  = clr ? '0 : cause;
        added = set_en ? set_bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= '0;
        end else begin
            cause <= kept | added;
        end
    end

    // R9
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr) |=> $stable(cause));

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
    parameter int SETTLE_W = 8
) (
    input  logic                         rc_clk,
    input  logic                         rst_n,
    input  logic                         stop_req,
    input  logic [swc_pkg::NUM_SRC-1:0]  wake_src,
    input  logic [swc_pkg::NUM_SRC-1:0]  wake_en,
    input  logic [SETTLE_W-1:0]          settle_len,
    input  logic                         cause_clr,
    output logic                         core_clk_en,
    output logic                         xosc_en,
    output logic [swc_pkg::NUM_SRC-1:0]  wake_cause
);

    import swc_pkg::*;

    localparam int SYNC_W = NUM_SRC + 1;

    swc_state_e          state_q;
    swc_state_e          state_d;
    logic [SYNC_W-1:0]   sync_q;
    logic [NUM_SRC-1:0]  src_s;
    logic [NUM_SRC-1:0]  hit_vec;
    logic                stop_s;
    logic                stop_prev_q;
    logic                stop_rise;
    logic                wake_hit;
    logic                settle_load;
    logic                settle_done;

    swc_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk      (rc_clk),
        .rst_n    (rst_n),
        .async_in ({stop_req, wake_src}),
        .sync_out (sync_q)
    );

    assign src_s    = sync_q[NUM_SRC-1:0];
    assign stop_s   = sync_q[NUM_SRC];
    assign hit_vec  = src_s & wake_en;
    assign wake_hit = |hit_vec;

    always_ff @(posedge rc_clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_prev_q <= 1'b0;
        end else begin
            stop_prev_q <= stop_s;
        end
    end

    assign stop_rise = stop_s & ~stop_prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_rise && !wake_hit) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                state_d = wake_hit ? ST_SETTLE : ST_STOP;
            end
            ST_STOP: begin
                if (wake_hit) begin
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge rc_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        core_clk_en = 1'b0;
        xosc_en     = 1'b0;
        unique case (state_q)
            ST_RUN:    begin core_clk_en = 1'b1; xosc_en = 1'b1; end
            ST_DRAIN:  begin core_clk_en = 1'b0; xosc_en = 1'b1; end
            ST_STOP:   begin core_clk_en = 1'b0; xosc_en = 1'b0; end
            ST_SETTLE: begin core_clk_en = 1'b0; xosc_en = 1'b1; end
        endcase
    end

    assign settle_load = (state_d == ST_SETTLE) && (state_q != ST_SETTLE);

    swc_settle_timer #(.CNT_W(SETTLE_W)) u_settle (
        .clk      (rc_clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (settle_len),
        .run      (state_q == ST_SETTLE),
        .done     (settle_done)
    );

    swc_cause_reg #(.N(NUM_SRC)) u_cause (
        .clk      (rc_clk),
        .rst_n    (rst_n),
        .set_en   (settle_load),
        .set_bits (hit_vec),
        .clr      (cause_clr),
        .cause    (wake_cause)
    );

    // R7
    gate_needs_osc_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        core_clk_en |-> xosc_en);

    // R7
    ungate_after_osc_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> $past(xosc_en));

    // R2
    osc_off_after_gate_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        $fell(xosc_en) |-> (!core_clk_en && !$past(core_clk_en)));

    // R8
    stop_blocked_chk: assert property (@(posedge rc_clk) disable iff (!rst_n)
        (core_clk_en && wake_hit) |=> core_clk_en);

endmodule

// File: tb/stop_wake_ctrl_tb_top.sv
module stop_wake_ctrl_tb_top;

    localparam int SW = 8;

    logic          rc_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_req = 1'b0;
    logic [2:0]    wake_src = 3'b000;
    logic [2:0]    wake_en = 3'b111;
    logic [SW-1:0] settle_len = 8'd5;
    logic          cause_clr = 1'b0;
    logic          core_clk_en;
    logic          xosc_en;
    logic [2:0]    wake_cause;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 rc_clk = ~rc_clk;

    stop_wake_ctrl #(.SETTLE_W(SW)) dut_i (
        .rc_clk      (rc_clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .wake_src    (wake_src),
        .wake_en     (wake_en),
        .settle_len  (settle_len),
        .cause_clr   (cause_clr),
        .core_clk_en (core_clk_en),
        .xosc_en     (xosc_en),
        .wake_cause  (wake_cause)
    );

    task automatic step(input int n);
        repeat (n) @(posedge rc_clk);
        @(negedge rc_clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // value packs {core_clk_en, xosc_en}
    function automatic int clkst();
        return {30'd0, core_clk_en, xosc_en};
    endfunction

    task automatic enter_stop(input string req);
        stop_req = 1'b1;
        step(3);
        chk({req, " drain gated, osc on"}, clkst(), 2'b01);
        step(1);
        chk({req, " stop both off"}, clkst(), 2'b00);
    endtask

    task automatic clear_cause();
        cause_clr = 1'b1;
        step(1);
        cause_clr = 1'b0;
        chk("R9 cause cleared", int'(wake_cause), 0);
    endtask

    task automatic t_reset();
        chk("R1 reset clocks", clkst(), 2'b11);
        chk("R1 reset cause", int'(wake_cause), 0);
    endtask

    task automatic t_wake(input int src, input bit pulse, input int len, input string req);
        settle_len = len[SW-1:0];
        enter_stop("R2");
        stop_req = 1'b0;
        wake_src[src] = 1'b1;
        if (pulse) begin
            step(1);
            wake_src[src] = 1'b0;
            step(2);
        end else begin
            step(3);
        end
        chk("R7 settle osc on, gated", clkst(), 2'b01);
        if (len > 0) begin
            step(len);
            chk("R7 still gated at settle end", clkst(), 2'b01);
        end
        step(1);
        chk({req, " run after settle"}, clkst(), 2'b11);
        chk({req, " cause bit"}, int'(wake_cause), 1 << src);
        wake_src = 3'b000;
        step(3);
        clear_cause();
    endtask

    task automatic t_disabled();
        wake_en = 3'b110;
        enter_stop("R2");
        stop_req = 1'b0;
        wake_src[0] = 1'b1;
        step(8);
        chk("R6 disabled no wake", clkst(), 2'b00);
        chk("R6 cause unchanged", int'(wake_cause), 0);
        wake_src[0] = 1'b0;
        wake_src[2] = 1'b1;
        step(1);
        wake_src[2] = 1'b0;
        step(2 + 6);
        chk("R5 timer wake after masked pin", clkst(), 2'b11);
        chk("R6 only enabled bit recorded", int'(wake_cause), 3'b100);
        wake_en = 3'b111;
        clear_cause();
    endtask

    task automatic t_pending();
        wake_src[1] = 1'b1;
        step(3);
        stop_req = 1'b1;
        step(8);
        chk("R8 stop ignored while pending", clkst(), 2'b11);
        stop_req = 1'b0;
        wake_src = 3'b000;
        step(3);
    endtask

    task automatic t_multi();
        enter_stop("R2");
        stop_req = 1'b0;
        wake_src = 3'b011;
        step(3 + 6);
        chk("R9 two-source wake run", clkst(), 2'b11);
        chk("R9 both cause bits", int'(wake_cause), 3'b011);
        wake_src = 3'b000;
        step(3);
        chk("R9 cause holds", int'(wake_cause), 3'b011);
        clear_cause();
    endtask

    task automatic t_reentry();
        enter_stop("R10");
        wake_src[2] = 1'b1;
        step(1);
        wake_src[2] = 1'b0;
        step(2 + 6);
        chk("R10 woke with request held", clkst(), 2'b11);
        step(10);
        chk("R10 held request no re-entry", clkst(), 2'b11);
        stop_req = 1'b0;
        step(3);
        enter_stop("R10 new edge");
        stop_req = 1'b0;
        wake_src[0] = 1'b1;
        step(3 + 6);
        chk("R3 exit after re-entry", clkst(), 2'b11);
        wake_src = 3'b000;
        step(3);
        clear_cause();
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_wake(0, 1'b0, 5, "R3");
        t_wake(1, 1'b0, 5, "R4");
        t_wake(2, 1'b1, 5, "R5");
        t_wake(2, 1'b1, 0, "R7 zero settle");
        settle_len = 8'd5;
        t_disabled();
        t_pending();
        t_multi();
        t_reentry();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule